// File: doc/BRIEF.md
# Integer Execute Unit with Immediate Handling

This block is the arithmetic and logic stage of a small 32-bit load/store processor. Each cycle it takes two register operands, a 16-bit immediate, a shift distance and a decoded operation code. From these it forms one result word and a signed-overflow flag. The operation code decides three things: whether the second operand is a register or the immediate, whether the immediate is widened with its sign bit or with zeros, and whether a signed overflow is reported at all.

The datapath is combinational. One register stage on the outputs gives the pipeline a clean boundary. When the flag is raised, the result still carries the wrapped value, and the surrounding pipeline decides whether to cancel the register write. Nothing inside the block reacts to an overflow.

Top module: `alu_exec`

## Requirements
- R1: While `rst_n` is low, `result_o` and `ovf_o` are 0 at every rising clock edge. After reset is released they stay 0 until the first operation has been captured.
- R2: Outputs are registered. The inputs present at a rising edge of `clk` appear on `result_o`/`ovf_o` after that edge and are held until the next edge.
- R3: The trapping forms ADD (code 0, a+b), SUB (code 2, a-b) and ADDI (code 11, a+sign-extended imm) give the wrapped 32-bit result. They raise `ovf_o` exactly when signed overflow occurs. For an add, that is operands of equal sign and a result of the other sign. For a subtract, that is operands of different sign and a result whose sign differs from `a_i`.
- R4: The non-trapping forms ADDU (code 1), SUBU (code 3) and ADDIU (code 12) give the same wrapped sums and differences with `ovf_o` always 0.
- R5: ADDI, ADDIU, SLTI (code 15) and SLTIU (code 16) widen the immediate by copying bit 15 into bits 31:16.
- R6: ANDI (code 13) and ORI (code 14) widen the immediate with zeros in bits 31:16 and AND/OR it with `a_i`.
- R7: LUI (code 17) outputs the immediate in bits 31:16 and zeros in bits 15:0. It ignores `a_i`.
- R8: AND (code 4), OR (code 5) and NOR (code 6) combine `a_i` and `b_i` bitwise. NOR is the inverse of the OR.
- R9: SLT (code 7) and SLTI compare as two's-complement values. SLTU (code 8) and SLTIU compare as unsigned values. Each outputs 1 when `a_i` is less than the second operand and 0 otherwise.
- R10: SLL (code 9) and SRL (code 10) shift `b_i` by `shamt_i` places, filling with zeros, and ignore `a_i`.
- R11: Op codes 18 to 31 give a result of 0 with `ovf_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 5 | Decoded operation code |
| a_i | input | 32 | First register operand |
| b_i | input | 32 | Second register operand, also the shift source |
| imm_i | input | 16 | Immediate field |
| shamt_i | input | 5 | Shift distance |
| result_o | output | 32 | Registered result |
| ovf_o | output | 1 | Registered signed-overflow flag |

## Verification
The bench builds the block with its default 32-bit word and 16-bit immediate. At these widths bit 15 of the immediate is the sign bit that extension copies, and the 5-bit shift field reaches a full 31-place shift in both directions. Both most-negative and most-positive operands are used, so every overflow direction of add, subtract and add-immediate can be compared against its non-trapping twin. The signed and unsigned compares are given the same operand bit patterns and must disagree.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [4:0] {
        OP_ADD   = 5'd0,
        OP_ADDU  = 5'd1,
        OP_SUB   = 5'd2,
        OP_SUBU  = 5'd3,
        OP_AND   = 5'd4,
        OP_OR    = 5'd5,
        OP_NOR   = 5'd6,
        OP_SLT   = 5'd7,
        OP_SLTU  = 5'd8,
        OP_SLL   = 5'd9,
        OP_SRL   = 5'd10,
        OP_ADDI  = 5'd11,
        OP_ADDIU = 5'd12,
        OP_ANDI  = 5'd13,
        OP_ORI   = 5'd14,
        OP_SLTI  = 5'd15,
        OP_SLTIU = 5'd16,
        OP_LUI   = 5'd17
    } alu_op_e;

    localparam int OP_W = 5;

endpackage

// File: rtl/alu_imm_ext.sv
module alu_imm_ext #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16
) (
    input  logic [IMM_W-1:0] imm_i,
    input  logic             sign_i,
    output logic [XLEN-1:0]  ext_o
);
    localparam int PAD_W = XLEN - IMM_W;

    logic fill;

    always_comb begin
        fill  = sign_i & imm_i[IMM_W-1];
        ext_o = {{PAD_W{fill}}, imm_i};
    end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic            sub_i,
    output logic [XLEN-1:0] sum_o,
    output logic            ovf_o
);
    localparam int MSB = XLEN - 1;

    logic [XLEN-1:0] b_eff;

    always_comb begin
        b_eff = sub_i ? ~b_i : b_i;
        sum_o = a_i + b_eff + {{(XLEN-1){1'b0}}, sub_i};
        // equal signs going in, other sign coming out
        ovf_o = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
    end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int XLEN = 32,
    parameter int SH_W = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] src_i,
    input  logic [SH_W-1:0] amt_i,
    input  logic            left_i,
    output logic [XLEN-1:0] dst_o
);
    logic [XLEN-1:0] stage [SH_W+1];

    assign stage[0] = src_i;

    for (genvar i = 0; i < SH_W; i++) begin : g_stage
        localparam int DIST = 1 << i;
        logic [XLEN-1:0] moved;
        always_comb begin
            moved = left_i ? (stage[i] << DIST) : (stage[i] >> DIST);
        end
        assign stage[i+1] = amt_i[i] ? moved : stage[i];
    end

    assign dst_o = stage[SH_W];
endmodule

// File: rtl/alu_exec.sv
module alu_exec
    import alu_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16,
    parameter int SH_W  = $clog2(XLEN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OP_W-1:0]    op_i,
    input  logic [XLEN-1:0]    a_i,
    input  logic [XLEN-1:0]    b_i,
    input  logic [IMM_W-1:0]   imm_i,
    input  logic [SH_W-1:0]    shamt_i,
    output logic [XLEN-1:0]    result_o,
    output logic               ovf_o
);
    localparam int LOW_W = XLEN - IMM_W;

    typedef struct packed {
        logic [XLEN-1:0] result;
        logic            ovf;
    } out_t;

    out_t out_d, out_q;

    alu_op_e         op;
    logic            use_imm, sign_ext, do_sub, trap, shl;
    logic [XLEN-1:0] imm_x, opnd_b, sum, shifted;
    logic            add_ovf, lt_s, lt_u;

    // decode: operand source, extension kind, add/sub, trapping
    always_comb begin
        op       = alu_op_e'(op_i);
        use_imm  = 1'b0;
        sign_ext = 1'b1;
        do_sub   = 1'b0;
        trap     = 1'b0;
        unique case (op)
            OP_ADD:   trap = 1'b1;
            OP_SUB:   begin do_sub = 1'b1; trap = 1'b1; end
            OP_SUBU:  do_sub = 1'b1;
            OP_ADDI:  begin use_imm = 1'b1; trap = 1'b1; end
            OP_ADDIU: use_imm = 1'b1;
            OP_ANDI:  begin use_imm = 1'b1; sign_ext = 1'b0; end
            OP_ORI:   begin use_imm = 1'b1; sign_ext = 1'b0; end
            OP_SLTI:  use_imm = 1'b1;
            OP_SLTIU: use_imm = 1'b1;
            default:  ;
        endcase
        shl = (op == OP_SLL);
    end

    alu_imm_ext #(.XLEN(XLEN), .IMM_W(IMM_W)) u_ext (
        .imm_i  (imm_i),
        .sign_i (sign_ext),
        .ext_o  (imm_x)
    );

    assign opnd_b = use_imm ? imm_x : b_i;

    alu_addsub #(.XLEN(XLEN)) u_add (
        .a_i   (a_i),
        .b_i   (opnd_b),
        .sub_i (do_sub),
        .sum_o (sum),
        .ovf_o (add_ovf)
    );

    alu_shifter #(.XLEN(XLEN), .SH_W(SH_W)) u_shift (
        .src_i  (b_i),
        .amt_i  (shamt_i),
        .left_i (shl),
        .dst_o  (shifted)
    );

    always_comb begin
        lt_s = $signed(a_i) < $signed(opnd_b);
        lt_u = a_i < opnd_b;
    end

    // next-state: result select and gated overflow
    always_comb begin
        out_d.result = '0;
        out_d.ovf    = trap & add_ovf;
        unique case (op)
            OP_ADD, OP_ADDU, OP_SUB, OP_SUBU,
            OP_ADDI, OP_ADDIU:  out_d.result = sum;
            OP_AND, OP_ANDI:    out_d.result = a_i & opnd_b;
            OP_OR, OP_ORI:      out_d.result = a_i | opnd_b;
            OP_NOR:             out_d.result = ~(a_i | opnd_b);
            OP_SLT, OP_SLTI:    out_d.result = {{(XLEN-1){1'b0}}, lt_s};
            OP_SLTU, OP_SLTIU:  out_d.result = {{(XLEN-1){1'b0}}, lt_u};
            OP_SLL, OP_SRL:     out_d.result = shifted;
            OP_LUI:             out_d.result = {imm_i, {LOW_W{1'b0}}};
            default:            out_d.result = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign result_o = out_q.result;
    assign ovf_o    = out_q.ovf;
endmodule

// File: rtl/alu_exec_chk.sv
module alu_exec_chk
    import alu_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [OP_W-1:0]  op_i,
    input logic [XLEN-1:0]  a_i,
    input logic [XLEN-1:0]  b_i,
    input logic [IMM_W-1:0] imm_i,
    input logic [XLEN-1:0]  result_o,
    input logic             ovf_o
);
    localparam int MSB = XLEN - 1;

    // R1: first edge out of reset still shows cleared outputs
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (result_o == '0 && !ovf_o));

    // R3: trapping add flags exactly the signed overflow
    p_add_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == OP_ADD) |->
        (ovf_o == (($past(a_i[MSB]) == $past(b_i[MSB])) &&
                   (result_o[MSB] != $past(a_i[MSB])))));

    // R4: non-trapping forms never flag
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(op_i) == OP_ADDU || $past(op_i) == OP_SUBU ||
                          $past(op_i) == OP_ADDIU)) |-> !ovf_o);

    // R7: upper immediate placement
    p_lui_place_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == OP_LUI) |->
        (result_o == {$past(imm_i), {(XLEN-IMM_W){1'b0}}}));

    // R9: compares produce a single bit
    p_compare_bool_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(op_i) == OP_SLT || $past(op_i) == OP_SLTU ||
                          $past(op_i) == OP_SLTI || $past(op_i) == OP_SLTIU)) |->
        (result_o[XLEN-1:1] == '0));

    // R11: unused codes give zero
    p_unused_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) > OP_LUI) |-> (result_o == '0 && !ovf_o));
endmodule

bind alu_exec alu_exec_chk #(.XLEN(XLEN), .IMM_W(IMM_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .imm_i    (imm_i),
    .result_o (result_o),
    .ovf_o    (ovf_o)
);

// File: tb/alu_exec_test.sv
module alu_exec_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op_i = '0;
    logic [31:0] a_i = '0, b_i = '0;
    logic [15:0] imm_i = '0;
    logic [4:0]  shamt_i = '0;
    logic [31:0] result_o;
    logic        ovf_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    alu_exec uut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .imm_i(imm_i), .shamt_i(shamt_i), .result_o(result_o), .ovf_o(ovf_o)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [4:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [15:0] imm;
        logic [4:0]  sh;
        logic [31:0] res;
        logic        ovf;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VECS [NV] = '{
        // R3 trapping add/sub/addi
        '{4'd3, 5'd0,  32'h7fffffff, 32'h00000001, 16'h0000, 5'd0, 32'h80000000, 1'b1},
        '{4'd3, 5'd0,  32'h80000000, 32'hffffffff, 16'h0000, 5'd0, 32'h7fffffff, 1'b1},
        '{4'd3, 5'd0,  32'h00000005, 32'hfffffffd, 16'h0000, 5'd0, 32'h00000002, 1'b0},
        '{4'd3, 5'd2,  32'h80000000, 32'h00000001, 16'h0000, 5'd0, 32'h7fffffff, 1'b1},
        '{4'd3, 5'd2,  32'h7fffffff, 32'hffffffff, 16'h0000, 5'd0, 32'h80000000, 1'b1},
        '{4'd3, 5'd2,  32'h00000010, 32'h00000003, 16'h0000, 5'd0, 32'h0000000d, 1'b0},
        '{4'd3, 5'd11, 32'h7fffffff, 32'h00000000, 16'h0001, 5'd0, 32'h80000000, 1'b1},
        // R4 non-trapping twins
        '{4'd4, 5'd1,  32'h7fffffff, 32'h00000001, 16'h0000, 5'd0, 32'h80000000, 1'b0},
        '{4'd4, 5'd3,  32'h80000000, 32'h00000001, 16'h0000, 5'd0, 32'h7fffffff, 1'b0},
        '{4'd4, 5'd12, 32'h7fffffff, 32'h00000000, 16'h0001, 5'd0, 32'h80000000, 1'b0},
        // R5 sign extension
        '{4'd5, 5'd11, 32'h00000010, 32'h00000000, 16'hffff, 5'd0, 32'h0000000f, 1'b0},
        '{4'd5, 5'd12, 32'h00000000, 32'h00000000, 16'h8000, 5'd0, 32'hffff8000, 1'b0},
        // R6 zero extension
        '{4'd6, 5'd13, 32'hffffffff, 32'h00000000, 16'h8001, 5'd0, 32'h00008001, 1'b0},
        '{4'd6, 5'd14, 32'h00010000, 32'h00000000, 16'h8000, 5'd0, 32'h00018000, 1'b0},
        // R7 upper immediate
        '{4'd7, 5'd17, 32'hffffffff, 32'hffffffff, 16'h1234, 5'd0, 32'h12340000, 1'b0},
        // R8 bitwise
        '{4'd8, 5'd4,  32'hf0f0f0f0, 32'hff00ff00, 16'h0000, 5'd0, 32'hf000f000, 1'b0},
        '{4'd8, 5'd5,  32'hf0f0f0f0, 32'h0f0f0000, 16'h0000, 5'd0, 32'hfffff0f0, 1'b0},
        '{4'd8, 5'd6,  32'hf0f0f0f0, 32'h0f0f0000, 16'h0000, 5'd0, 32'h00000f0f, 1'b0},
        // R9 signed vs unsigned compare
        '{4'd9, 5'd7,  32'hffffffff, 32'h00000001, 16'h0000, 5'd0, 32'h00000001, 1'b0},
        '{4'd9, 5'd8,  32'hffffffff, 32'h00000001, 16'h0000, 5'd0, 32'h00000000, 1'b0},
        '{4'd9, 5'd15, 32'h00000000, 32'h00000000, 16'hffff, 5'd0, 32'h00000000, 1'b0},
        '{4'd9, 5'd15, 32'hfffffffe, 32'h00000000, 16'hffff, 5'd0, 32'h00000001, 1'b0},
        '{4'd9, 5'd16, 32'h00000005, 32'h00000000, 16'hffff, 5'd0, 32'h00000001, 1'b0},
        // R10 shifts of b, zero fill
        '{4'd10, 5'd9,  32'hdeadbeef, 32'h00000001, 16'h0000, 5'd31, 32'h80000000, 1'b0},
        '{4'd10, 5'd10, 32'hdeadbeef, 32'h80000000, 16'h0000, 5'd31, 32'h00000001, 1'b0},
        '{4'd10, 5'd10, 32'h00000000, 32'hf0000000, 16'h0000, 5'd4,  32'h0f000000, 1'b0},
        '{4'd10, 5'd9,  32'h00000000, 32'h000000ff, 16'h0000, 5'd0,  32'h000000ff, 1'b0},
        // R11 unused codes after an overflow
        '{4'd3,  5'd0,  32'h7fffffff, 32'h00000001, 16'h0000, 5'd0, 32'h80000000, 1'b1},
        '{4'd11, 5'd18, 32'h00000001, 32'h00000001, 16'hffff, 5'd3, 32'h00000000, 1'b0},
        '{4'd11, 5'd31, 32'hffffffff, 32'hffffffff, 16'hffff, 5'd7, 32'h00000000, 1'b0}
    };

    task automatic check(input int req, input logic [31:0] er, input logic eo);
        total++;
        if (result_o !== er || ovf_o !== eo) begin
            bad++;
            $display("FAIL R%0d: result=%h ovf=%b expected result=%h ovf=%b",
                     req, result_o, ovf_o, er, eo);
        end
    endtask

    task automatic drive(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] imm, input logic [4:0] sh);
        op_i = op; a_i = a; b_i = b; imm_i = imm; shamt_i = sh;
    endtask

    initial begin
        // R1: reset state with a live overflowing input present
        drive(5'd0, 32'h7fffffff, 32'h1, 16'h0, 5'd0);
        repeat (3) @(negedge clk);
        check(1, 32'h0, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].imm, VECS[i].sh);
            @(negedge clk);
            check(int'(VECS[i].req), VECS[i].res, VECS[i].ovf);
        end

        // R2: output holds until the capturing edge
        drive(5'd17, 32'h0, 32'h0, 16'habcd, 5'd0);
        @(negedge clk);
        check(2, 32'habcd0000, 1'b0);
        drive(5'd1, 32'h1, 32'h2, 16'h0, 5'd0);
        #5;
        check(2, 32'habcd0000, 1'b0);
        @(negedge clk);
        check(2, 32'h00000003, 1'b0);

        // R1: reset in the middle of a run clears both outputs
        drive(5'd2, 32'h80000000, 32'h1, 16'h0, 5'd0);
        @(negedge clk);
        check(3, 32'h7fffffff, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        check(1, 32'h0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check(3, 32'h7fffffff, 1'b1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: result=%h ovf=%b expected completion", result_o, ovf_o);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule